// File: doc/BRIEF.md
# Fully Associative Tag Directory

This block is the tag side of a small fully associative cache. A byte address is split into a block tag (upper bits) and a block offset (lower bits). There is no set index, so a block may live in any entry. Every entry keeps a valid flag and a stored tag, and every entry has its own comparator. A lookup compares the incoming tag against all entries at once. It reports hit or miss, a one-hot match vector and an entry number. The entry number is the only link to the data array, which lives elsewhere.

On a miss the block picks an entry for the incoming block. The lowest-numbered empty entry is used if one exists; otherwise the least recently used entry is chosen. The block then waits for the requester to signal that the fill is done. The fill stores the pending tag, sets the valid flag and makes that entry the most recently used. Recency is held as one age value per entry. Age 0 is the newest and ENTRIES-1 the oldest. Hits and fills both count as uses.

Control is a three-state machine:
- `ST_IDLE`: ready for a request. It moves to `ST_LOOKUP` when `req_valid` is high.
- `ST_LOOKUP`: presents the result for one cycle. It returns to `ST_IDLE` on a hit and moves to `ST_FILL` on a miss.
- `ST_FILL`: waits for the fill. It returns to `ST_IDLE` when `fill_valid` is high.

Top module: `fa_tag_dir`

## Requirements
- R1: The tag is `req_addr[31:5]`. The offset bits `[4:0]` do not take part in matching, so two addresses that differ only in bits [4:0] match the same entry.
- R2: A synchronous reset (`rst` high at a clock edge) clears every valid flag. After reset `req_ready` is 1, `rsp_valid` is 0, and the next lookup misses and reports entry 0.
- R3: A request accepted while `req_ready` is 1 gives `rsp_valid` high in the following cycle. If a valid entry holds the same tag, `rsp_hit` is 1 and `rsp_entry` gives that entry's number.
- R4: On a miss, `rsp_hit` is 0 and `rsp_entry` gives the entry chosen for allocation. The block then holds `req_ready` low until a cycle with `fill_valid` high.
- R5: If any entry is empty, a miss allocates the lowest-numbered empty entry.
- R6: If every entry is valid, a miss allocates the least recently used entry. Each hit and each fill marks its entry as most recently used.
- R7: A fill writes the pending tag into the allocated entry and sets its valid flag. A later lookup of that tag hits that entry.
- R8: `rsp_hit_vec` has bit i set only for a hitting entry i. It has at most one bit set, and it is all zeros on a miss or when `rsp_valid` is 0.
- R9: An entry whose valid flag is clear never hits, even if its stored tag equals the lookup tag.
- R10: `req_valid` is ignored while `req_ready` is 0. It produces no response and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Byte address of the lookup |
| req_ready | output | 1 | High in `ST_IDLE`; a request is taken only then |
| fill_valid | input | 1 | Fill done for the pending miss |
| rsp_valid | output | 1 | Result valid (the `ST_LOOKUP` cycle) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_entry | output | 3 | Entry hit, or entry allocated on a miss |
| rsp_hit_vec | output | 8 | One-hot per-entry match vector |

## Verification
The following rules are checked by assertions in every cycle:
- A reported hit always points at a valid entry whose stored tag equals the registered lookup tag.
- The match vector is never more than one-hot.
- A miss with free space never names an occupied entry.
- A fill leaves its entry valid.
- The ages always contain exactly one oldest entry.
- The fill wait holds until `fill_valid`.

Only the bench scenarios show the rest:
- The actual LRU order after a mix of hits and fills.
- That offset bits are ignored.
- That requests made while busy leave no trace.
- That a reset hides tags that are still stored.

// File: rtl/fa_tag_pkg.sv
package fa_tag_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL
    } dir_state_e;
endpackage

// File: rtl/fa_match_array.sv
module fa_match_array #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 27
) (
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [ENTRIES-1:0]            valid,
    input  logic [TAG_W-1:0]              key,
    output logic [ENTRIES-1:0]            hit_vec
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == key);
    end
endmodule

// File: rtl/fa_onehot_enc.sv
module fa_onehot_enc #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0] vec,
    output logic [IDX_W-1:0]   idx,
    output logic               any
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (vec[i]) idx = idx | IDX_W'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/fa_victim_sel.sv
module fa_victim_sel #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][IDX_W-1:0] ages,
    output logic [IDX_W-1:0]              victim
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    logic found;

    always_comb begin
        victim = '0;
        found  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid[i] && !found) begin
                victim = IDX_W'(i);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (ages[i] == OLDEST) victim = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/fa_age_tracker.sv
module fa_age_tracker #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          touch,
    input  logic [IDX_W-1:0]              touch_idx,
    output logic [ENTRIES-1:0][IDX_W-1:0] ages
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0]   ref_age;
    logic [ENTRIES-1:0] oldest_vec;

    assign ref_age = ages[touch_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ages[i] <= IDX_W'(i);
        end else if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx) ages[i] <= '0;
                else if (ages[i] < ref_age) ages[i] <= ages[i] + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_old
        assign oldest_vec[g] = (ages[g] == OLDEST);
    end

    AST_TOUCH_MRU: assert property (@(posedge clk) disable iff (rst)
        touch |=> ages[$past(touch_idx)] == '0); // R6
    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest_vec) == 1); // R6
endmodule

// File: rtl/fa_tag_dir.sv
module fa_tag_dir
    import fa_tag_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 5,
    parameter int ENTRIES = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [ADDR_W-1:0]          req_addr,
    output logic                       req_ready,
    input  logic                       fill_valid,
    output logic                       rsp_valid,
    output logic                       rsp_hit,
    output logic [$clog2(ENTRIES)-1:0] rsp_entry,
    output logic [ENTRIES-1:0]         rsp_hit_vec
);
    localparam int TAG_W = ADDR_W - OFF_W;
    localparam int IDX_W = $clog2(ENTRIES);

    dir_state_e                      state, state_nx;
    logic [TAG_W-1:0]                key_q;
    logic [IDX_W-1:0]                victim_q;
    logic [ENTRIES-1:0][TAG_W-1:0]   tag_q;
    logic [ENTRIES-1:0]              valid_q;
    logic [ENTRIES-1:0]              hit_vec;
    logic [IDX_W-1:0]                hit_idx;
    logic                            hit_any;
    logic [IDX_W-1:0]                victim_now;
    logic [ENTRIES-1:0][IDX_W-1:0]   ages;
    logic                            touch;
    logic [IDX_W-1:0]                touch_idx;
    logic                            do_fill;

    fa_match_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
        .tags(tag_q), .valid(valid_q), .key(key_q), .hit_vec(hit_vec)
    );

    fa_onehot_enc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_enc (
        .vec(hit_vec), .idx(hit_idx), .any(hit_any)
    );

    fa_victim_sel #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .valid(valid_q), .ages(ages), .victim(victim_now)
    );

    fa_age_tracker #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_age (
        .clk(clk), .rst(rst), .touch(touch), .touch_idx(touch_idx), .ages(ages)
    );

    assign do_fill   = (state == ST_FILL) && fill_valid;
    assign touch     = ((state == ST_LOOKUP) && hit_any) || do_fill;
    assign touch_idx = do_fill ? victim_q : hit_idx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_LOOKUP;
            ST_LOOKUP: state_nx = hit_any ? ST_IDLE : ST_FILL;
            ST_FILL:   if (fill_valid) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // request and allocation registers
    always_ff @(posedge clk) begin
        if ((state == ST_IDLE) && req_valid) key_q <= req_addr[ADDR_W-1:OFF_W];
        if ((state == ST_LOOKUP) && !hit_any) victim_q <= victim_now;
    end

    // tag store
    always_ff @(posedge clk) begin
        if (do_fill) tag_q[victim_q] <= key_q;
    end

    always_ff @(posedge clk) begin
        if (rst)          valid_q <= '0;
        else if (do_fill) valid_q[victim_q] <= 1'b1;
    end

    // outputs
    always_comb begin
        req_ready   = (state == ST_IDLE);
        rsp_valid   = (state == ST_LOOKUP);
        rsp_hit     = rsp_valid && hit_any;
        rsp_entry   = rsp_valid ? (hit_any ? hit_idx : victim_now) : '0;
        rsp_hit_vec = rsp_valid ? hit_vec : '0;
    end

    AST_TAG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> {{OFF_W{1'b0}}, key_q} == ($past(req_addr) >> OFF_W)); // R1
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> valid_q == '0); // R2
    AST_HIT_IS_VALID: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (valid_q[rsp_entry] && tag_q[rsp_entry] == key_q)); // R9
    AST_VEC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_hit_vec)); // R8
    AST_FREE_SLOT: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit && !(&valid_q)) |-> !valid_q[rsp_entry]); // R5
    AST_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_FILL) && !fill_valid) |=> (state == ST_FILL) && !req_ready); // R4
    AST_FILL_SETS: assert property (@(posedge clk) disable iff (rst)
        do_fill |=> valid_q[$past(victim_q)] && req_ready); // R7
endmodule

// File: tb/fa_tag_dir_test.sv
module fa_tag_dir_test;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 8;

    typedef struct {
        bit    hit;
        int    entry;
        int    vec;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic        fill_valid = 1'b0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [2:0]  rsp_entry;
    logic [7:0]  rsp_hit_vec;

    int   checks = 0;
    int   failures = 0;
    int   cycles = 0;
    exp_t sb[$];

    fa_tag_dir uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .fill_valid(fill_valid), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_entry(rsp_entry), .rsp_hit_vec(rsp_hit_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pop and compare on every response
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sb.size() == 0) begin
                chk("R10 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.req, " hit"}, int'(rsp_hit), int'(e.hit));
                chk({e.req, " entry"}, int'(rsp_entry), e.entry);
                chk({e.req, " vec R8"}, int'(rsp_hit_vec), e.vec);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // driver: one lookup, with a fill if the block waits for one
    task automatic access(input logic [26:0] tag, input logic [4:0] off,
                          input bit hit, input int entry, input string req,
                          input bit poke, input logic [26:0] poke_tag);
        exp_t e;
        e.hit = hit;
        e.entry = entry;
        e.vec = hit ? (1 << entry) : 0;
        e.req = req;
        sb.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {tag, off};
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        if (!req_ready) begin
            if (poke) begin
                req_valid = 1'b1;
                req_addr  = {poke_tag, 5'd0};
                @(negedge clk);
                req_valid = 1'b0;
                chk("R10 no response while busy", int'(rsp_valid), 0);
                chk("R4 ready low while waiting", int'(req_ready), 0);
            end
            fill_valid = 1'b1;
            @(negedge clk);
            fill_valid = 1'b0;
            chk("R4 ready after fill", int'(req_ready), 1);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R2 ready after reset", int'(req_ready), 1);
        chk("R2 no response after reset", int'(rsp_valid), 0);
    endtask

    initial begin
        do_reset();
        access(27'h100, 5'd0, 0, 0, "R2 R5 first miss", 0, '0);
        access(27'h100, 5'h1f, 1, 0, "R1 R3 offset ignored", 0, '0);
        for (int i = 1; i < ENTRIES; i++)
            access(27'h100 + 27'(i), 5'd3, 0, i, "R5 fill empty", 0, '0);
        access(27'h105, 5'd0, 1, 5, "R3 R7 hit filled", 0, '0);
        access(27'h100, 5'd8, 1, 0, "R6 touch entry0", 0, '0);
        // oldest now entry1, then 2,3,4,6,7
        access(27'h200, 5'd0, 0, 1, "R6 lru victim", 0, '0);
        access(27'h101, 5'd0, 0, 2, "R6 evicted misses", 1, 27'h300);
        access(27'h300, 5'd0, 0, 3, "R10 ignored tag absent", 0, '0);
        access(27'h200, 5'd0, 1, 1, "R7 refill hits", 0, '0);
        access(27'h101, 5'd0, 1, 2, "R7 refill hits 2", 0, '0);
        do_reset();
        access(27'h100, 5'd0, 0, 0, "R9 stale tag no hit", 0, '0);
        access(27'h100, 5'd0, 1, 0, "R3 hit after refill", 0, '0);
        repeat (3) @(negedge clk);
        chk("R3 scoreboard drained", sb.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule